// File: doc/BRIEF.md
# ISA I/O Chip-Select Decoder

This block turns the low ten address lines of an ISA bus, the address-enable line and the two I/O strobes into active-low chip selects for the peripherals of a multi-function I/O card. It serves two serial UARTs, a parallel port controller, a floppy controller and two IDE channels. Each IDE channel gets one select for its command block and one for its control block. Configuration inputs, normally tied to jumpers or switches, move each serial port to its alternate base, pick or disable the parallel port base, and enable or disable the floppy and each IDE channel.

The decode itself is purely combinational. A registered copy of the same select vector is also produced. It loads on every clock edge where the sample input is high and holds otherwise, so a synchronous consumer or a bench can observe a stable snapshot.

Top module: `isa_csdec_top`

## Requirements
- R1: Select bit 0 (serial A) is asserted for 0x3F8..0x3FF when `com_a_alt_i` is 0, and for 0x3E8..0x3EF when it is 1.
- R2: Select bit 1 (serial B) is asserted for 0x2F8..0x2FF when `com_b_alt_i` is 0, and for 0x2E8..0x2EF when it is 1.
- R3: Select bit 2 (parallel) depends on `lpt_mode_i`. Code 00 covers 0x378..0x37F, 01 covers 0x278..0x27F, 10 covers 0x3BC..0x3BF, and 11 never asserts it.
- R4: Select bit 4 is the primary IDE command block at 0x1F0..0x1F7, gated by `ide0_en_i`. Bit 6 is the secondary IDE command block at 0x170..0x177, gated by `ide1_en_i`.
- R5: Select bit 5 is the primary IDE control block at 0x3F6..0x3F7, gated by `ide0_en_i`. Bit 7 is the secondary control block at 0x376..0x377, gated by `ide1_en_i`. Address 0x3F7 goes to bit 5 only while the floppy is disabled.
- R6: Select bit 3 (floppy) covers 0x3F2..0x3F5 and 0x3F7, gated by `fdc_en_i`. It is never asserted at 0x3F6.
- R7: While `aen_i` is high, every select is deasserted (all ones).
- R8: While both `ior_n_i` and `iow_n_i` are high, every select is deasserted.
- R9: For any address and configuration, at most one bit of `cs_n_o` is low.
- R10: `cs_q_n_o` is all ones after reset. On a rising clock edge with `sample_i` high it takes the value `cs_n_o` had before the edge. With `sample_i` low it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered select copy |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_i | input | 1 | Load enable for the registered copy |
| addr_i | input | 10 | ISA I/O address lines |
| aen_i | input | 1 | Address enable, high during DMA cycles |
| ior_n_i | input | 1 | Active-low I/O read strobe |
| iow_n_i | input | 1 | Active-low I/O write strobe |
| com_a_alt_i | input | 1 | Moves serial A to its alternate base |
| com_b_alt_i | input | 1 | Moves serial B to its alternate base |
| lpt_mode_i | input | 2 | Parallel port base code |
| fdc_en_i | input | 1 | Floppy decode enable |
| ide0_en_i | input | 1 | Primary IDE decode enable |
| ide1_en_i | input | 1 | Secondary IDE decode enable |
| cs_n_o | output | 8 | Combinational active-low selects, bit map as in R1..R6 |
| cs_q_n_o | output | 8 | Registered copy of the selects |

## Verification
On every clock, the embedded properties check four things: at most one select is low, address enable and idle strobes force all selects high, the floppy select never fires at 0x3F6, and a disabled parallel port stays quiet. They also check that the registered copy follows or holds according to the sample input. Only the bench scenarios can show that each window sits at the right base for every alternate setting. The bench sweeps all 1024 addresses under all 128 configurations. It also covers how 0x3F7 moves between the floppy and IDE control selects as the floppy enable changes, and the reset value of the registered copy.

// File: rtl/isa_csdec_pkg.sv
package isa_csdec_pkg;
    localparam int ADDR_W = 10;
    localparam int NUM_CS = 8;

    typedef enum int unsigned {
        SEL_COM_A    = 0,
        SEL_COM_B    = 1,
        SEL_LPT      = 2,
        SEL_FDC      = 3,
        SEL_IDE0_CMD = 4,
        SEL_IDE0_CTL = 5,
        SEL_IDE1_CMD = 6,
        SEL_IDE1_CTL = 7
    } sel_idx_e;

    localparam logic [ADDR_W-1:0] COM_A_MAIN = 10'h3F8;
    localparam logic [ADDR_W-1:0] COM_A_ALT  = 10'h3E8;
    localparam logic [ADDR_W-1:0] COM_B_MAIN = 10'h2F8;
    localparam logic [ADDR_W-1:0] COM_B_ALT  = 10'h2E8;
    localparam logic [ADDR_W-1:0] LPT_BASE0  = 10'h378;
    localparam logic [ADDR_W-1:0] LPT_BASE1  = 10'h278;
    localparam logic [ADDR_W-1:0] LPT_BASE2  = 10'h3BC;
    localparam logic [ADDR_W-1:0] FDC_BLOCK  = 10'h3F0;

    function automatic logic [ADDR_W-1:0] ide_cmd_base(input int ch);
        return (ch == 0) ? 10'h1F0 : 10'h170;
    endfunction

    function automatic logic [ADDR_W-1:0] ide_ctl_base(input int ch);
        return (ch == 0) ? 10'h3F6 : 10'h376;
    endfunction
endpackage

// File: rtl/isa_csdec_window.sv
module isa_csdec_window #(
    parameter int ADDR_W    = 10,
    parameter int SPAN_LOG2 = 3
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] base_i,
    output logic              hit_o
);
    localparam logic [ADDR_W-1:0] ZERO = '0;

    // Window of 2**SPAN_LOG2 bytes: upper address bits must agree.
    always_comb begin
        hit_o = (((addr_i ^ base_i) >> SPAN_LOG2) == ZERO);
    end
endmodule

// File: rtl/isa_csdec_hitmap.sv
module isa_csdec_hitmap
    import isa_csdec_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int NC = NUM_CS
) (
    input  logic [AW-1:0] addr_i,
    input  logic          com_a_alt_i,
    input  logic          com_b_alt_i,
    input  logic [1:0]    lpt_mode_i,
    input  logic          fdc_en_i,
    input  logic [1:0]    ide_en_i,
    output logic [NC-1:0] hit_o
);
    logic [AW-1:0] com_a_base, com_b_base, lpt_wide_base;
    logic          com_a_hit, com_b_hit, lpt_wide_hit, lpt_narrow_hit, fdc_blk_hit;
    logic [1:0]    ide_cmd_hit, ide_ctl_hit;
    logic          fdc_offset_ok;

    always_comb begin
        com_a_base    = com_a_alt_i ? COM_A_ALT : COM_A_MAIN;
        com_b_base    = com_b_alt_i ? COM_B_ALT : COM_B_MAIN;
        lpt_wide_base = lpt_mode_i[0] ? LPT_BASE1 : LPT_BASE0;
    end

    isa_csdec_window #(.ADDR_W(AW), .SPAN_LOG2(3)) u_com_a (
        .addr_i(addr_i), .base_i(com_a_base), .hit_o(com_a_hit));
    isa_csdec_window #(.ADDR_W(AW), .SPAN_LOG2(3)) u_com_b (
        .addr_i(addr_i), .base_i(com_b_base), .hit_o(com_b_hit));
    isa_csdec_window #(.ADDR_W(AW), .SPAN_LOG2(3)) u_lpt_wide (
        .addr_i(addr_i), .base_i(lpt_wide_base), .hit_o(lpt_wide_hit));
    isa_csdec_window #(.ADDR_W(AW), .SPAN_LOG2(2)) u_lpt_narrow (
        .addr_i(addr_i), .base_i(LPT_BASE2), .hit_o(lpt_narrow_hit));
    isa_csdec_window #(.ADDR_W(AW), .SPAN_LOG2(3)) u_fdc (
        .addr_i(addr_i), .base_i(FDC_BLOCK), .hit_o(fdc_blk_hit));

    for (genvar ch = 0; ch < 2; ch++) begin : g_ide
        isa_csdec_window #(.ADDR_W(AW), .SPAN_LOG2(3)) u_cmd (
            .addr_i(addr_i), .base_i(ide_cmd_base(ch)), .hit_o(ide_cmd_hit[ch]));
        isa_csdec_window #(.ADDR_W(AW), .SPAN_LOG2(1)) u_ctl (
            .addr_i(addr_i), .base_i(ide_ctl_base(ch)), .hit_o(ide_ctl_hit[ch]));
    end

    always_comb begin
        // Floppy block skips offsets 0, 1 and 6 of its 8-byte block.
        unique case (addr_i[2:0])
            3'd0, 3'd1, 3'd6: fdc_offset_ok = 1'b0;
            default:          fdc_offset_ok = 1'b1;
        endcase
    end

    always_comb begin
        hit_o               = '0;
        hit_o[SEL_COM_A]    = com_a_hit;
        hit_o[SEL_COM_B]    = com_b_hit;
        unique case (lpt_mode_i)
            2'b00, 2'b01: hit_o[SEL_LPT] = lpt_wide_hit;
            2'b10:        hit_o[SEL_LPT] = lpt_narrow_hit;
            default:      hit_o[SEL_LPT] = 1'b0;
        endcase
        hit_o[SEL_FDC]      = fdc_en_i & fdc_blk_hit & fdc_offset_ok;
        hit_o[SEL_IDE0_CMD] = ide_en_i[0] & ide_cmd_hit[0];
        hit_o[SEL_IDE0_CTL] = ide_en_i[0] & ide_ctl_hit[0];
        hit_o[SEL_IDE1_CMD] = ide_en_i[1] & ide_cmd_hit[1];
        hit_o[SEL_IDE1_CTL] = ide_en_i[1] & ide_ctl_hit[1];
    end
endmodule

// File: rtl/isa_csdec_capture.sv
module isa_csdec_capture #(
    parameter int NC = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sample_i,
    input  logic [NC-1:0] d_i,
    output logic [NC-1:0] q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_o <= '1;
        end else if (sample_i) begin
            q_o <= d_i;
        end
    end

    AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        sample_i |=> (q_o == $past(d_i)));  // R10
    AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_i |=> $stable(q_o));  // R10
endmodule

// File: rtl/isa_csdec_top.sv
module isa_csdec_top
    import isa_csdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              aen_i,
    input  logic              ior_n_i,
    input  logic              iow_n_i,
    input  logic              com_a_alt_i,
    input  logic              com_b_alt_i,
    input  logic [1:0]        lpt_mode_i,
    input  logic              fdc_en_i,
    input  logic              ide0_en_i,
    input  logic              ide1_en_i,
    output logic [NUM_CS-1:0] cs_n_o,
    output logic [NUM_CS-1:0] cs_q_n_o
);
    logic [NUM_CS-1:0] raw_hit, resolved, cs_act;
    logic              bus_active;

    isa_csdec_hitmap #(.AW(ADDR_W), .NC(NUM_CS)) u_hitmap (
        .addr_i      (addr_i),
        .com_a_alt_i (com_a_alt_i),
        .com_b_alt_i (com_b_alt_i),
        .lpt_mode_i  (lpt_mode_i),
        .fdc_en_i    (fdc_en_i),
        .ide_en_i    ({ide1_en_i, ide0_en_i}),
        .hit_o       (raw_hit)
    );

    always_comb begin
        // Shared byte: floppy wins, IDE control yields to it.
        resolved               = raw_hit;
        resolved[SEL_IDE0_CTL] = raw_hit[SEL_IDE0_CTL] & ~raw_hit[SEL_FDC];
        bus_active             = ~aen_i & (~ior_n_i | ~iow_n_i);
        cs_act                 = resolved & {NUM_CS{bus_active}};
        cs_n_o                 = ~cs_act;
    end

    isa_csdec_capture #(.NC(NUM_CS)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (sample_i),
        .d_i      (cs_n_o),
        .q_o      (cs_q_n_o)
    );

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n_o));  // R9
    AST_AEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        aen_i |-> (&cs_n_o));  // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ior_n_i && iow_n_i) |-> (&cs_n_o));  // R8
    AST_FDC_NOT_3F6: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == 10'h3F6) |-> cs_n_o[SEL_FDC]);  // R6
    AST_LPT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (lpt_mode_i == 2'b11) |-> cs_n_o[SEL_LPT]);  // R3
endmodule

// File: tb/tb_isa_csdec_top.sv
module tb_isa_csdec_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_i = 1'b0;
    logic [9:0] addr_i = '0;
    logic       aen_i = 1'b0;
    logic       ior_n_i = 1'b1;
    logic       iow_n_i = 1'b1;
    logic       com_a_alt_i = 1'b0;
    logic       com_b_alt_i = 1'b0;
    logic [1:0] lpt_mode_i = 2'b00;
    logic       fdc_en_i = 1'b1;
    logic       ide0_en_i = 1'b1;
    logic       ide1_en_i = 1'b1;
    logic [7:0] cs_n_o, cs_q_n_o;

    int tests = 0;
    int fails = 0;
    logic [7:0] exp_q = 8'hFF;

    always #2 clk = ~clk;

    isa_csdec_top dut (
        .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .addr_i(addr_i),
        .aen_i(aen_i), .ior_n_i(ior_n_i), .iow_n_i(iow_n_i),
        .com_a_alt_i(com_a_alt_i), .com_b_alt_i(com_b_alt_i),
        .lpt_mode_i(lpt_mode_i), .fdc_en_i(fdc_en_i),
        .ide0_en_i(ide0_en_i), .ide1_en_i(ide1_en_i),
        .cs_n_o(cs_n_o), .cs_q_n_o(cs_q_n_o)
    );

    function automatic bit in_rng(int a, int lo, int n);
        return (a >= lo) && (a < lo + n);
    endfunction

    // Behavioural reference: active-high expected selects.
    function automatic logic [7:0] model(int a);
        logic [7:0] e = '0;
        if (aen_i || (ior_n_i && iow_n_i)) return '0;
        e[0] = in_rng(a, com_a_alt_i ? 'h3E8 : 'h3F8, 8);
        e[1] = in_rng(a, com_b_alt_i ? 'h2E8 : 'h2F8, 8);
        case (lpt_mode_i)
            2'b00: e[2] = in_rng(a, 'h378, 8);
            2'b01: e[2] = in_rng(a, 'h278, 8);
            2'b10: e[2] = in_rng(a, 'h3BC, 4);
            default: e[2] = 1'b0;
        endcase
        e[3] = fdc_en_i && (in_rng(a, 'h3F2, 4) || a == 'h3F7);
        e[4] = ide0_en_i && in_rng(a, 'h1F0, 8);
        e[5] = ide0_en_i && (a == 'h3F6 || (a == 'h3F7 && !fdc_en_i));
        e[6] = ide1_en_i && in_rng(a, 'h170, 8);
        e[7] = ide1_en_i && in_rng(a, 'h376, 2);
        return e;
    endfunction

    function automatic string req_of(logic [7:0] diff);
        if (diff[0]) return "R1";
        if (diff[1]) return "R2";
        if (diff[2]) return "R3";
        if (diff[3]) return "R6";
        if (diff[4] || diff[6]) return "R4";
        return "R5";
    endfunction

    task automatic step(input int a, input logic aen, input logic rn, input logic wn,
                        input logic smp, input string tag);
        logic [7:0] exp_n;
        @(negedge clk);
        addr_i = a[9:0]; aen_i = aen; ior_n_i = rn; iow_n_i = wn; sample_i = smp;
        #1;
        exp_n = ~model(a);
        tests++;
        if (cs_n_o !== exp_n) begin
            fails++;
            $display("FAIL %s addr=%h cs_n actual=%b expected=%b",
                     (tag == "") ? req_of(cs_n_o ^ exp_n) : tag, a, cs_n_o, exp_n);
        end
        tests++;
        if ($countones(~cs_n_o) > 1) begin
            fails++;
            $display("FAIL R9 addr=%h actual=%b expected at most one low", a, cs_n_o);
        end
        if (smp) exp_q = exp_n;
        @(posedge clk);
        #1;
        tests++;
        if (cs_q_n_o !== exp_q) begin
            fails++;
            $display("FAIL R10 addr=%h cs_q_n actual=%b expected=%b", a, cs_q_n_o, exp_q);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        tests++;
        if (cs_q_n_o !== 8'hFF) begin
            fails++;
            $display("FAIL R10 reset actual=%b expected=%b", cs_q_n_o, 8'hFF);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1..R6, R9, R10: every address under every configuration.
        for (int cfg = 0; cfg < 128; cfg++) begin
            @(negedge clk);
            com_a_alt_i = cfg[0]; com_b_alt_i = cfg[1]; lpt_mode_i = cfg[3:2];
            fdc_en_i = cfg[4]; ide0_en_i = cfg[5]; ide1_en_i = cfg[6];
            for (int a = 0; a < 1024; a++)
                step(a, 1'b0, a[0], ~a[0], 1'b1, "");
        end

        // R7: DMA cycle, all strobes active.
        @(negedge clk);
        com_a_alt_i = 0; com_b_alt_i = 0; lpt_mode_i = 0;
        fdc_en_i = 1; ide0_en_i = 1; ide1_en_i = 1;
        for (int a = 0; a < 1024; a++) step(a, 1'b1, 1'b0, 1'b0, 1'b1, "R7");

        // R8: no strobe.
        for (int a = 0; a < 1024; a++) step(a, 1'b0, 1'b1, 1'b1, 1'b1, "R8");

        // R10: capture at 0x3F8, then hold while other addresses decode.
        step('h3F8, 1'b0, 1'b0, 1'b1, 1'b1, "R10");
        step('h1F3, 1'b0, 1'b0, 1'b1, 1'b0, "R10");
        step('h2F8, 1'b0, 1'b1, 1'b0, 1'b0, "R10");
        step('h170, 1'b0, 1'b1, 1'b0, 1'b1, "R10");

        // R5/R6: shared byte 0x3F7 follows the floppy enable.
        step('h3F7, 1'b0, 1'b0, 1'b1, 1'b1, "R6");
        @(negedge clk); fdc_en_i = 0;
        step('h3F7, 1'b0, 1'b0, 1'b1, 1'b1, "R5");
        step('h3F6, 1'b0, 1'b0, 1'b1, 1'b1, "R5");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule